// File: doc/BRIEF.md
# Banked Register File with Indirect Extended-RAM Port

This block presents a byte-wide, 128-location host address space. The lower part holds a control byte, a constant status byte and a fixed region of general user memory. The upper 64 locations are banked. A select bit in the control byte chooses what they show. Bank 0 shows more user memory. Bank 1 shows a window of extended registers: read-only identification bytes, two extension control bytes, a two-byte pointer and a single data port.

The data port reads and writes a larger, parameter-sized extended RAM at the location the pointer holds. A burst-enable bit in an extension control byte makes the pointer advance by one after every data-port access. A host can therefore stream a block of bytes through one address after it loads the pointer once.

Host accesses are single-cycle strobes. Read data is registered and appears the cycle after the read strobe. The identification bytes come from parameters.

Top module: `xbr_top`

## Requirements
- R1: After reset, `rd_data` is 0x00, the control byte at 0x0A reads 0x00 (bank 0), the pointer reads 0, burst mode is off, and both extension control bytes read 0x00.
- R2: Address 0x0A is a read/write control byte that returns all 8 written bits. Its bit 4 set to 1 selects bank 1, and set to 0 selects bank 0.
- R3: Address 0x0D always reads 0x80: bit 7 is a constant valid flag and bits 6..0 are 0. Writes to it have no effect.
- R4: Addresses 0x0E..0x3F are 50 bytes of read/write user memory, reachable in either bank.
- R5: In bank 0, addresses 0x40..0x7F are 64 bytes of read/write user memory. Their contents are kept unchanged by any access made while bank 1 is selected.
- R6: In bank 1, 0x40 reads the MODEL_ID parameter, 0x41..0x46 read serial bytes 1..6 (byte k is SERIAL_NO[8k-1:8k-8]), and 0x47 reads CRC_BYTE. Writes to these addresses are ignored.
- R7: In bank 1, 0x50 is the pointer low byte and 0x51 is the pointer high byte, both read/write. Pointer bits at or above log2(XRAM_BYTES) are not stored and read as 0.
- R8: In bank 1, a write to 0x53 stores the byte into the extended RAM at the pointer, and a read of 0x53 returns the byte at the pointer.
- R9: In bank 1, 0x4A and 0x4B are read/write extension control bytes. Bit 5 of 0x4A enables burst mode: each data-port read or write then adds one to the pointer. When the bit is clear, data-port accesses leave the pointer unchanged.
- R10: A pointer step from the last extended-RAM location (XRAM_BYTES-1) wraps to 0.
- R11: Addresses 0x00..0x09, 0x0B, 0x0C and every bank-1 address not listed above read 0x00 and ignore writes.
- R12: `rd_data` carries the addressed byte from the clock edge that samples `rd_en` until the next read. If `wr_en` and `rd_en` are both high in one cycle, the write is performed, the read is dropped and `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 7 | Byte address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read data |

## Verification
Pointer wrap is the hardest case to reach from the ports. It needs bank 1 selected, burst mode on, and the pointer loaded to the last RAM location through both pointer bytes. A high-byte write of 0xFF sets the pointer there and at the same time shows that the unstored bits read back as 0. The bench follows that write with one burst write and reads the pointer bytes back. The burst sequence streams eight bytes out through the data port and back in. The bench reads the pointer part-way through, so a wrong step count shows up on its own and is not hidden behind a data mismatch. The bank-isolation checks write through bank 1 at addresses that are user memory in bank 0. They then return to bank 0 and read those bytes.

// File: rtl/xbr_pkg.sv
// Package: shared address map, source encoding and decode result type for
// the banked register file. Assumes a 7-bit byte address space.
package xbr_pkg;

    localparam logic [6:0] ADR_CTRL   = 7'h0A;
    localparam logic [6:0] ADR_STAT   = 7'h0D;
    localparam logic [6:0] ADR_URAM0  = 7'h0E;
    localparam logic [6:0] ADR_UPPER  = 7'h40;
    localparam logic [6:0] ADR_CRC    = 7'h47;
    localparam logic [6:0] ADR_XCTL0  = 7'h4A;
    localparam logic [6:0] ADR_XCTL1  = 7'h4B;
    localparam logic [6:0] ADR_PTR_LO = 7'h50;
    localparam logic [6:0] ADR_PTR_HI = 7'h51;
    localparam logic [6:0] ADR_DPORT  = 7'h53;

    localparam int BANK_BIT  = 4;
    localparam int BURST_BIT = 5;
    localparam logic [7:0] STAT_VALUE = 8'h80;

    // Depth of user memory: lower region plus the bank-0 upper region.
    localparam int URAM_DEPTH = 128 - int'(ADR_URAM0);

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_CTRL,
        SRC_STAT,
        SRC_URAM,
        SRC_ID,
        SRC_XCTL,
        SRC_PTR,
        SRC_XRAM
    } src_e;

    typedef struct packed {
        src_e       src;
        logic [6:0] uram_idx;
        logic [2:0] id_idx;
        logic       sub_sel;   // XCTL: 0=0x4A 1=0x4B ; PTR: 0=low 1=high
    } dec_t;

endpackage

// File: rtl/xbr_addr_decode.sv
// Module: combinational address decoder. Maps a host address and the
// current bank bit onto a data source and local indices. Assumes the
// package address map; no state.
module xbr_addr_decode
    import xbr_pkg::*;
(
    input  logic [6:0] addr,
    input  logic       bank1,
    output dec_t       dec
);

    // Purpose: classify the address into one source and compute sub-indices.
    always_comb begin
        dec          = '0;
        dec.src      = SRC_NONE;
        dec.uram_idx = addr - ADR_URAM0;
        dec.id_idx   = addr[2:0];
        dec.sub_sel  = addr[0];
        if (addr == ADR_CTRL) begin
            dec.src = SRC_CTRL;
        end else if (addr == ADR_STAT) begin
            dec.src = SRC_STAT;
        end else if (addr >= ADR_URAM0 && addr < ADR_UPPER) begin
            dec.src = SRC_URAM;
        end else if (addr >= ADR_UPPER && !bank1) begin
            dec.src = SRC_URAM;
        end else if (addr >= ADR_UPPER) begin
            if (addr <= ADR_CRC) begin
                dec.src = SRC_ID;
            end else if (addr == ADR_XCTL0 || addr == ADR_XCTL1) begin
                dec.src = SRC_XCTL;
            end else if (addr == ADR_PTR_LO || addr == ADR_PTR_HI) begin
                dec.src = SRC_PTR;
            end else if (addr == ADR_DPORT) begin
                dec.src = SRC_XRAM;
            end
        end
    end

endmodule

// File: rtl/xbr_user_ram.sv
// Module: flop-based user memory with combinational read. Assumes the
// index is below DEPTH whenever the caller uses the read value; contents
// are not reset.
module xbr_user_ram #(
    parameter int DEPTH = 114,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    // Purpose: store a byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we && (int'(idx) < DEPTH)) begin
            mem[idx] <= wdata;
        end
    end

    // Purpose: return the indexed byte, 0 when out of range.
    always_comb begin
        rdata = 8'h00;
        if (int'(idx) < DEPTH) begin
            rdata = mem[idx];
        end
    end

    AST_URAM_STORE: assert property (@(posedge clk)
        (we && int'(idx) < DEPTH) |=> (mem[$past(idx)] == $past(wdata))); // R4

endmodule

// File: rtl/xbr_xram_ptr.sv
// Module: extended-RAM pointer. Loads its low and high bytes from host
// writes and steps by one (with natural wrap) on request. Assumes
// 9 <= AW <= 15 so the high byte holds AW-8 stored bits.
module xbr_xram_ptr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [7:0]    wdata,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic [7:0]    hi_byte
);

    // Purpose: load or step the pointer; loads take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ld_lo) begin
            ptr[7:0] <= wdata;
        end else if (ld_hi) begin
            ptr[AW-1:8] <= wdata[AW-9:0];
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Purpose: present the stored high bits zero-extended to a byte.
    always_comb begin
        hi_byte = {{(16-AW){1'b0}}, ptr[AW-1:8]};
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_lo && !ld_hi && !step) |=> $stable(ptr)); // R9

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_lo && !ld_hi) |=> (ptr == AW'($past(ptr) + 1'b1))); // R10

endmodule

// File: rtl/xbr_xram.sv
// Module: extended RAM, single port, synchronous read. The read register
// changes only on a read strobe. Contents are not reset.
module xbr_xram #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    // Purpose: write on strobe; register the addressed byte on read strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/xbr_top.sv
// Module: banked register file top. Holds the control and extension
// bytes, decodes the host address, routes writes and registers reads.
// Assumes single-cycle strobes; a write wins over a read in one cycle.
// XRAM_BYTES must be a power of two between 512 and 32768.
module xbr_top
    import xbr_pkg::*;
#(
    parameter int          XRAM_BYTES = 2048,
    parameter logic [7:0]  MODEL_ID   = 8'h5A,
    parameter logic [47:0] SERIAL_NO  = 48'h6655_4433_2211,
    parameter logic [7:0]  CRC_BYTE   = 8'hC3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data
);

    localparam int XAW = $clog2(XRAM_BYTES);
    localparam int UIW = $clog2(URAM_DEPTH);

    logic [7:0]     ctrl_q;
    logic [7:0]     xctl0_q;
    logic [7:0]     xctl1_q;
    logic [7:0]     reg_rd_q;
    src_e           src_q;
    dec_t           dec;
    logic           wr_go;
    logic           rd_go;
    logic [7:0]     uram_rd;
    logic [7:0]     xram_rd;
    logic [XAW-1:0] ptr;
    logic [7:0]     ptr_hi;
    logic           xram_we;
    logic           xram_re;
    logic           burst;
    logic [7:0]     rd_mux;
    logic [7:0]     id_tab [8];

    assign wr_go = wr_en;
    assign rd_go = rd_en && !wr_en;
    assign burst = xctl0_q[BURST_BIT];

    xbr_addr_decode u_dec (
        .addr  (addr),
        .bank1 (ctrl_q[BANK_BIT]),
        .dec   (dec)
    );

    xbr_user_ram #(.DEPTH(URAM_DEPTH)) u_uram (
        .clk   (clk),
        .we    (wr_go && dec.src == SRC_URAM),
        .idx   (dec.uram_idx[UIW-1:0]),
        .wdata (wr_data),
        .rdata (uram_rd)
    );

    assign xram_we = wr_go && dec.src == SRC_XRAM;
    assign xram_re = rd_go && dec.src == SRC_XRAM;

    xbr_xram_ptr #(.AW(XAW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (wr_go && dec.src == SRC_PTR && !dec.sub_sel),
        .ld_hi   (wr_go && dec.src == SRC_PTR && dec.sub_sel),
        .wdata   (wr_data),
        .step    (burst && (xram_we || xram_re)),
        .ptr     (ptr),
        .hi_byte (ptr_hi)
    );

    xbr_xram #(.DEPTH(XRAM_BYTES)) u_xram (
        .clk   (clk),
        .we    (xram_we),
        .re    (xram_re),
        .addr  (ptr),
        .wdata (wr_data),
        .rdata (xram_rd)
    );

    // Identification table built from parameters, one entry per byte.
    for (genvar k = 0; k < 8; k++) begin : g_id
        if (k == 0) begin : g_model
            assign id_tab[k] = MODEL_ID;
        end else if (k == 7) begin : g_crc
            assign id_tab[k] = CRC_BYTE;
        end else begin : g_serial
            assign id_tab[k] = SERIAL_NO[8*(k-1) +: 8];
        end
    end

    // Purpose: update control and extension bytes on host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= 8'h00;
            xctl0_q <= 8'h00;
            xctl1_q <= 8'h00;
        end else if (wr_go) begin
            if (dec.src == SRC_CTRL) begin
                ctrl_q <= wr_data;
            end
            if (dec.src == SRC_XCTL && !dec.sub_sel) begin
                xctl0_q <= wr_data;
            end
            if (dec.src == SRC_XCTL && dec.sub_sel) begin
                xctl1_q <= wr_data;
            end
        end
    end

    // Purpose: select the byte for the current address (non-RAM sources).
    always_comb begin
        unique case (dec.src)
            SRC_CTRL: rd_mux = ctrl_q;
            SRC_STAT: rd_mux = STAT_VALUE;
            SRC_URAM: rd_mux = uram_rd;
            SRC_ID:   rd_mux = id_tab[dec.id_idx];
            SRC_XCTL: rd_mux = dec.sub_sel ? xctl1_q : xctl0_q;
            SRC_PTR:  rd_mux = dec.sub_sel ? ptr_hi : ptr[7:0];
            default:  rd_mux = 8'h00;
        endcase
    end

    // Purpose: register read data and its source on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd_q <= 8'h00;
            src_q    <= SRC_NONE;
        end else if (rd_go) begin
            reg_rd_q <= rd_mux;
            src_q    <= dec.src;
        end
    end

    assign rd_data = (src_q == SRC_XRAM) ? xram_rd : reg_rd_q;

    AST_STAT_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == ADR_STAT) |=> (rd_data == STAT_VALUE)); // R3

    AST_MODEL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && ctrl_q[BANK_BIT] && addr == ADR_UPPER)
        |=> (rd_data == MODEL_ID)); // R6

    AST_LOW_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr < ADR_CTRL) |=> (rd_data == 8'h00)); // R11

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en) |=> $stable(rd_data)); // R12

endmodule

// File: tb/xbr_top_tb_top.sv
// Directed bench for the banked register file; one task per scenario.
module xbr_top_tb_top;

    localparam int          XB     = 2048;
    localparam logic [7:0]  MODEL  = 8'h5A;
    localparam logic [47:0] SERIAL = 48'h6655_4433_2211;
    localparam logic [7:0]  CRC    = 8'hC3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;

    xbr_top #(.XRAM_BYTES(XB), .MODEL_ID(MODEL), .SERIAL_NO(SERIAL),
              .CRC_BYTE(CRC)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic expect_rd(input string req, input logic [6:0] a, input logic [7:0] e);
        logic [7:0] v;
        rd(a, v);
        check(req, v, e);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rd_data", rd_data, 8'h00);
        expect_rd("R1 ctrl", 7'h0A, 8'h00);
        wr(7'h0A, 8'h10);
        expect_rd("R1 ptr lo", 7'h50, 8'h00);
        expect_rd("R1 ptr hi", 7'h51, 8'h00);
        expect_rd("R1 xctl0", 7'h4A, 8'h00);
        expect_rd("R1 xctl1", 7'h4B, 8'h00);
        wr(7'h0A, 8'h00);
    endtask

    task automatic t_ctrl_stat();
        wr(7'h0A, 8'hE7);
        expect_rd("R2 ctrl rw", 7'h0A, 8'hE7);
        wr(7'h0A, 8'h00);
        expect_rd("R3 stat", 7'h0D, 8'h80);
        wr(7'h0D, 8'h7F);
        expect_rd("R3 stat write ignored", 7'h0D, 8'h80);
    endtask

    task automatic t_banks();
        wr(7'h0E, 8'h11);
        wr(7'h3F, 8'h22);
        wr(7'h40, 8'h77);
        wr(7'h4A, 8'h21);
        wr(7'h7F, 8'h88);
        wr(7'h0A, 8'h10);
        expect_rd("R2 bank1 model", 7'h40, MODEL);
        expect_rd("R9 xctl0 not user ram", 7'h4A, 8'h00);
        expect_rd("R4 low ram in bank1", 7'h0E, 8'h11);
        wr(7'h3F, 8'h23);
        wr(7'h7F, 8'h99);
        expect_rd("R11 bank1 unmapped read", 7'h7F, 8'h00);
        wr(7'h0A, 8'h00);
        expect_rd("R5 bank0 0x40 kept", 7'h40, 8'h77);
        expect_rd("R5 bank0 0x4A kept", 7'h4A, 8'h21);
        expect_rd("R5 bank0 0x7F kept", 7'h7F, 8'h88);
        expect_rd("R4 low ram 0x3F", 7'h3F, 8'h23);
    endtask

    task automatic t_id();
        wr(7'h0A, 8'h10);
        expect_rd("R6 model", 7'h40, MODEL);
        for (int k = 1; k <= 6; k++) begin
            expect_rd("R6 serial", 7'(7'h40 + k), SERIAL[8*(k-1) +: 8]);
        end
        expect_rd("R6 crc", 7'h47, CRC);
        wr(7'h40, 8'hEE);
        wr(7'h47, 8'h00);
        expect_rd("R6 model write ignored", 7'h40, MODEL);
        expect_rd("R6 crc write ignored", 7'h47, CRC);
        wr(7'h48, 8'h5C);
        expect_rd("R11 bank1 0x48", 7'h48, 8'h00);
        expect_rd("R11 low 0x05", 7'h05, 8'h00);
        wr(7'h0B, 8'hFF);
        expect_rd("R11 low 0x0B", 7'h0B, 8'h00);
        wr(7'h4B, 8'h96);
        expect_rd("R9 xctl1 rw", 7'h4B, 8'h96);
        wr(7'h0A, 8'h00);
    endtask

    task automatic t_ptr_nonburst();
        wr(7'h0A, 8'h10);
        wr(7'h4A, 8'h00);
        wr(7'h50, 8'h00);
        wr(7'h51, 8'hFF);
        expect_rd("R7 ptr hi masked", 7'h51, 8'h07);
        wr(7'h51, 8'h02);
        expect_rd("R7 ptr hi", 7'h51, 8'h02);
        wr(7'h53, 8'h5A);
        wr(7'h53, 8'h6B);
        expect_rd("R9 no step on write", 7'h50, 8'h00);
        expect_rd("R8 dport read", 7'h53, 8'h6B);
        expect_rd("R8 dport read again", 7'h53, 8'h6B);
        expect_rd("R9 no step on read", 7'h50, 8'h00);
    endtask

    task automatic t_burst();
        wr(7'h4A, 8'h20);
        wr(7'h50, 8'h00);
        wr(7'h51, 8'h01);
        for (int i = 0; i < 8; i++) begin
            wr(7'h53, 8'(i * 17 + 3));
        end
        expect_rd("R9 burst write step", 7'h50, 8'h08);
        wr(7'h50, 8'h00);
        for (int i = 0; i < 8; i++) begin
            expect_rd("R8 burst readback", 7'h53, 8'(i * 17 + 3));
        end
        expect_rd("R9 burst read step", 7'h50, 8'h08);
        expect_rd("R9 burst hi", 7'h51, 8'h01);
        wr(7'h50, 8'h00);
        wr(7'h51, 8'h02);
        expect_rd("R8 other location untouched", 7'h53, 8'h6B);
    endtask

    task automatic t_wrap();
        wr(7'h50, 8'hFF);
        wr(7'h51, 8'hFF);
        wr(7'h53, 8'hAA);
        expect_rd("R10 wrap lo", 7'h50, 8'h00);
        expect_rd("R10 wrap hi", 7'h51, 8'h00);
        wr(7'h50, 8'hFF);
        wr(7'h51, 8'h07);
        expect_rd("R10 last byte", 7'h53, 8'hAA);
        expect_rd("R10 wrap after read", 7'h50, 8'h00);
        wr(7'h4A, 8'h00);
        wr(7'h0A, 8'h00);
    endtask

    task automatic t_collision();
        expect_rd("R12 setup", 7'h0D, 8'h80);
        @(negedge clk);
        addr = 7'h0E; wr_data = 8'h3C; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R12 read dropped", rd_data, 8'h80);
        repeat (2) @(negedge clk);
        check("R12 holds idle", rd_data, 8'h80);
        expect_rd("R12 write done", 7'h0E, 8'h3C);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_ctrl_stat();
        t_banks();
        t_id();
        t_ptr_nonburst();
        t_burst();
        t_wrap();
        t_collision();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule